// File: doc/BRIEF.md
# Stall-Only Pipeline Hazard Controller

This block is the pipeline-register control for a five-stage in-order core (fetch, decode, execute, memory, writeback) built without operand forwarding. Every cycle it looks at the two register numbers the decode-stage instruction wants to read, the six destination register numbers still pending in later stages, the opcodes sitting in decode, execute and memory, and the branch outcome computed in execute. From these it drives a hold (stall) and a squash (bubble) line for each of the five pipeline registers.

Three situations are recognised: an operand that is still being written by an older instruction, a return instruction somewhere between decode and memory, and a conditional jump in execute that was predicted taken but resolved not taken. When several are present at once a fixed priority picks one reaction: the wrong-path squash wins over everything, and a pending operand wins over a return. The outputs are purely combinational and are meant to feed the enable and clear inputs of the pipeline registers directly.

Top module: `hazard_ctrl`

## Requirements
- R1: A data hazard exists when a decode source (`dec_src_a` or `dec_src_b`) equals any one of the six pending destinations `exe_dst_calc`, `exe_dst_load`, `mem_dst_alu`, `mem_dst_load`, `wb_dst_alu`, `wb_dst_load`; each of the six alone is sufficient.
- R2: A source equal to the no-register code 4'hF never raises a data hazard, even when a destination also holds 4'hF.
- R3: A return is in flight when the return opcode 4'h9 is present in `dec_op`, `exe_op` or `mem_op`.
- R4: A mispredict exists only when `exe_op` holds the conditional-jump opcode 4'h7 and `exe_cond` is 0; a taken jump or any other opcode is not a mispredict.
- R5: On a mispredict, `d_bubble` and `e_bubble` are 1 and `f_stall`, `d_stall` are 0, regardless of the other two conditions.
- R6: On a data hazard without a mispredict, `f_stall`, `d_stall` and `e_bubble` are 1 and `d_bubble` is 0, whether or not a return is in flight.
- R7: On a return with neither other condition, `f_stall` and `d_bubble` are 1 while `d_stall` and `e_bubble` are 0.
- R8: `f_bubble`, `e_stall`, `m_stall`, `m_bubble`, `w_stall` and `w_bubble` are 0 under every input.
- R9: No pipeline register ever sees its stall and bubble lines high together.
- R10: With none of the three conditions present, all ten outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | 4 | First register read by the decode-stage instruction |
| dec_src_b | input | 4 | Second register read by the decode-stage instruction |
| exe_dst_calc | input | 4 | Destination computed in execute for the ALU result |
| exe_dst_load | input | 4 | Memory-load destination held in the execute register |
| mem_dst_alu | input | 4 | ALU destination held in the memory register |
| mem_dst_load | input | 4 | Load destination held in the memory register |
| wb_dst_alu | input | 4 | ALU destination held in the writeback register |
| wb_dst_load | input | 4 | Load destination held in the writeback register |
| dec_op | input | 4 | Opcode in decode |
| exe_op | input | 4 | Opcode in execute |
| mem_op | input | 4 | Opcode in memory |
| exe_cond | input | 1 | Branch condition computed in execute (1 = taken) |
| f_stall | output | 1 | Hold the fetch register |
| f_bubble | output | 1 | Squash the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Squash the decode register |
| e_stall | output | 1 | Hold the execute register |
| e_bubble | output | 1 | Squash the execute register |
| m_stall | output | 1 | Hold the memory register |
| m_bubble | output | 1 | Squash the memory register |
| w_stall | output | 1 | Hold the writeback register |
| w_bubble | output | 1 | Squash the writeback register |

## Verification
The embedded checks assume every input is a known value once it is sampled, and they skip evaluation while any input is unknown; the bench drives all inputs to defined values before the first comparison and only ever changes them together, on the rising clock edge, with comparisons made on the falling edge. They also assume a mispredict can only come from the jump opcode in execute, so the bench builds its combined cases by placing the jump opcode in execute and the return opcode in decode or memory. Destination values are chosen to avoid accidental matches except where a hazard is intended, and a pseudo-random sweep then covers arbitrary mixtures against the reference model.

// File: rtl/hazard_pkg.sv
// Shared widths, code points and the control bundle for the hazard controller.
// Assumes a 4-bit register file index with all-ones reserved for "no register".
package hazard_pkg;
    localparam int REG_W      = 4;
    localparam int OP_W       = 4;
    localparam int N_DST      = 6;
    localparam logic [REG_W-1:0] REG_NONE = '1;
    localparam logic [OP_W-1:0]  OP_RET   = 4'h9;
    localparam logic [OP_W-1:0]  OP_JCC   = 4'h7;

    // Stall/bubble pair for one pipeline register.
    typedef struct packed {
        logic stall;
        logic bubble;
    } stage_ctl_t;
endpackage

// File: rtl/hz_raw_detect.sv
// Read-after-write detector: flags a decode source that matches any pending
// destination. Assumes no forwarding exists, so every pending write counts.
module hz_raw_detect #(
    parameter int REG_W = hazard_pkg::REG_W,
    parameter int N_DST = hazard_pkg::N_DST,
    parameter logic [REG_W-1:0] REG_NONE = hazard_pkg::REG_NONE
) (
    input  logic [1:0][REG_W-1:0]      src,
    input  logic [N_DST-1:0][REG_W-1:0] dst,
    output logic                       hazard
);
    logic [1:0] per_src;

    for (genvar s = 0; s < 2; s++) begin : g_src
        // Compare one source against every pending destination.
        always_comb begin
            logic hit;
            hit = 1'b0;
            for (int d = 0; d < N_DST; d++) begin
                if (dst[d] == src[s]) hit = 1'b1;
            end
            per_src[s] = hit && (src[s] != REG_NONE);
            if (!$isunknown(src[s])) begin
                p_none_quiet_r2: assert (!(src[s] == REG_NONE && per_src[s]))
                    else $error("none-code source flagged a hazard");
            end
        end
    end

    // Either source hitting is a hazard.
    assign hazard = |per_src;
endmodule

// File: rtl/hz_flow_detect.sv
// Control-flow detector: a return anywhere from decode to memory, and a
// conditional jump in execute that resolved not taken.
module hz_flow_detect #(
    parameter int OP_W = hazard_pkg::OP_W,
    parameter logic [OP_W-1:0] OP_RET = hazard_pkg::OP_RET,
    parameter logic [OP_W-1:0] OP_JCC = hazard_pkg::OP_JCC
) (
    input  logic [2:0][OP_W-1:0] ops,
    input  logic                 exe_op_is,
    input  logic [OP_W-1:0]      exe_op,
    input  logic                 exe_cond,
    output logic                 ret_live,
    output logic                 mispredict
);
    logic [2:0] ret_at;

    for (genvar i = 0; i < 3; i++) begin : g_ret
        assign ret_at[i] = (ops[i] == OP_RET);
    end

    // Gather the return flags and decide the wrong-path case.
    always_comb begin
        ret_live   = |ret_at;
        mispredict = exe_op_is && (exe_op == OP_JCC) && !exe_cond;
        if (!$isunknown({exe_op, exe_cond})) begin
            p_jump_only_r4: assert (!(mispredict && (exe_op != OP_JCC || exe_cond)))
                else $error("mispredict without a not-taken jump");
        end
    end
endmodule

// File: rtl/hz_arbiter.sv
// Priority resolver: mispredict first, then data hazard, then return.
// Produces one stall/bubble pair per pipeline register.
module hz_arbiter
    import hazard_pkg::*;
#(
    parameter int N_STAGE = 5
) (
    input  logic       hazard,
    input  logic       ret_live,
    input  logic       mispredict,
    output stage_ctl_t ctl [N_STAGE]
);
    localparam int F = 0, D = 1, E = 2;

    // Map the active conditions onto per-stage actions.
    always_comb begin
        for (int s = 0; s < N_STAGE; s++) ctl[s] = '0;
        if (mispredict) begin
            ctl[D].bubble = 1'b1;
            ctl[E].bubble = 1'b1;
        end else if (hazard) begin
            ctl[F].stall  = 1'b1;
            ctl[D].stall  = 1'b1;
            ctl[E].bubble = 1'b1;
        end else if (ret_live) begin
            ctl[F].stall  = 1'b1;
            ctl[D].bubble = 1'b1;
        end
        if (!$isunknown({hazard, ret_live, mispredict})) begin
            for (int s = 0; s < N_STAGE; s++) begin
                p_excl_r9: assert (!(ctl[s].stall && ctl[s].bubble))
                    else $error("stall and bubble together");
            end
            p_squash_first_r5: assert (!(mispredict && (ctl[F].stall || ctl[D].stall)))
                else $error("front held during mispredict");
            p_hold_decode_r6: assert (!(hazard && !mispredict && ctl[D].bubble))
                else $error("decode squashed during data hazard");
            p_ret_keeps_exe_r7: assert (!(ret_live && !hazard && !mispredict && ctl[E].bubble))
                else $error("execute squashed on return alone");
        end
    end
endmodule

// File: rtl/hazard_ctrl.sv
// Top of the stall-only hazard controller. Purely combinational; packs the
// stage inputs for the detectors and spreads the resolved pairs onto ports.
module hazard_ctrl
    import hazard_pkg::*;
(
    input  logic [3:0] dec_src_a,
    input  logic [3:0] dec_src_b,
    input  logic [3:0] exe_dst_calc,
    input  logic [3:0] exe_dst_load,
    input  logic [3:0] mem_dst_alu,
    input  logic [3:0] mem_dst_load,
    input  logic [3:0] wb_dst_alu,
    input  logic [3:0] wb_dst_load,
    input  logic [3:0] dec_op,
    input  logic [3:0] exe_op,
    input  logic [3:0] mem_op,
    input  logic       exe_cond,
    output logic       f_stall,
    output logic       f_bubble,
    output logic       d_stall,
    output logic       d_bubble,
    output logic       e_stall,
    output logic       e_bubble,
    output logic       m_stall,
    output logic       m_bubble,
    output logic       w_stall,
    output logic       w_bubble
);
    localparam int N_STAGE = 5;

    logic       hazard, ret_live, mispredict;
    stage_ctl_t ctl [N_STAGE];

    hz_raw_detect u_raw (
        .src    ({dec_src_b, dec_src_a}),
        .dst    ({wb_dst_load, wb_dst_alu, mem_dst_load, mem_dst_alu,
                  exe_dst_load, exe_dst_calc}),
        .hazard (hazard)
    );

    hz_flow_detect u_flow (
        .ops        ({mem_op, exe_op, dec_op}),
        .exe_op_is  (1'b1),
        .exe_op     (exe_op),
        .exe_cond   (exe_cond),
        .ret_live   (ret_live),
        .mispredict (mispredict)
    );

    hz_arbiter #(.N_STAGE(N_STAGE)) u_arb (
        .hazard     (hazard),
        .ret_live   (ret_live),
        .mispredict (mispredict),
        .ctl        (ctl)
    );

    // Spread the resolved pairs onto the port list.
    always_comb begin
        {f_stall, f_bubble} = ctl[0];
        {d_stall, d_bubble} = ctl[1];
        {e_stall, e_bubble} = ctl[2];
        {m_stall, m_bubble} = ctl[3];
        {w_stall, w_bubble} = ctl[4];
    end
endmodule

// File: tb/sim_hazard_ctrl.sv
// Bench: drives inputs on the rising edge, compares all ten outputs with a
// behavioural model on the falling edge.
module sim_hazard_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [3:0] sa, sb, d0, d1, d2, d3, d4, d5, op_d, op_e, op_m;
    logic       cond;
    logic f_st, f_bu, d_st, d_bu, e_st, e_bu, m_st, m_bu, w_st, w_bu;

    int checks = 0, errors = 0;

    hazard_ctrl u0 (
        .dec_src_a(sa), .dec_src_b(sb),
        .exe_dst_calc(d0), .exe_dst_load(d1), .mem_dst_alu(d2),
        .mem_dst_load(d3), .wb_dst_alu(d4), .wb_dst_load(d5),
        .dec_op(op_d), .exe_op(op_e), .mem_op(op_m), .exe_cond(cond),
        .f_stall(f_st), .f_bubble(f_bu), .d_stall(d_st), .d_bubble(d_bu),
        .e_stall(e_st), .e_bubble(e_bu), .m_stall(m_st), .m_bubble(m_bu),
        .w_stall(w_st), .w_bubble(w_bu)
    );

    // Reference: outputs packed f_st,f_bu,d_st,d_bu,e_st,e_bu,m_st,m_bu,w_st,w_bu.
    function automatic logic [9:0] model();
        logic [3:0] q [$];
        bit haz = 0, ret = 0, mis;
        q = '{d0, d1, d2, d3, d4, d5};
        foreach (q[i]) begin
            if (sa != 4'hF && sa == q[i]) haz = 1;
            if (sb != 4'hF && sb == q[i]) haz = 1;
        end
        ret = (op_d == 4'h9) || (op_e == 4'h9) || (op_m == 4'h9);
        mis = (op_e == 4'h7) && !cond;
        if (mis)      return 10'b00_01_01_00_00;
        else if (haz) return 10'b10_10_01_00_00;
        else if (ret) return 10'b10_01_00_00_00;
        else          return 10'b0;
    endfunction

    task automatic setv(input logic [3:0] a, b, x0, x1, x2, x3, x4, x5,
                        input logic [3:0] od, oe, om, input logic c);
        @(posedge clk);
        sa = a; sb = b; d0 = x0; d1 = x1; d2 = x2; d3 = x3; d4 = x4; d5 = x5;
        op_d = od; op_e = oe; op_m = om; cond = c;
        @(negedge clk);
    endtask

    task automatic check(input string tag);
        logic [9:0] got, exp;
        got = {f_st, f_bu, d_st, d_bu, e_st, e_bu, m_st, m_bu, w_st, w_bu};
        exp = model();
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic check_val(input string tag, input logic [9:0] exp);
        logic [9:0] got;
        got = {f_st, f_bu, d_st, d_bu, e_st, e_bu, m_st, m_bu, w_st, w_bu};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, got, exp);
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        sa = 4'hF; sb = 4'hF; d0 = 4'h0; d1 = 4'h0; d2 = 4'h0; d3 = 4'h0;
        d4 = 4'h0; d5 = 4'h0; op_d = 4'h0; op_e = 4'h0; op_m = 4'h0; cond = 1'b1;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R10 reset idle", 10'b0);

        // R1: each destination slot alone, from either source.
        for (int k = 0; k < 6; k++) begin
            logic [3:0] x [6];
            for (int j = 0; j < 6; j++) x[j] = 4'(j + 1);
            x[k] = 4'hA;
            setv(4'hA, 4'hC, x[0], x[1], x[2], x[3], x[4], x[5], 4'h0, 4'h0, 4'h0, 1'b1);
            check_val("R1 R6 src_a slot", 10'b10_10_01_00_00);
            setv(4'hC, 4'hA, x[0], x[1], x[2], x[3], x[4], x[5], 4'h0, 4'h0, 4'h0, 1'b1);
            check_val("R1 R6 src_b slot", 10'b10_10_01_00_00);
        end
        // R2: none-code sources against none-code destinations.
        setv(4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 1'b1);
        check_val("R2 none code quiet", 10'b0);
        setv(4'hF, 4'hB, 4'hF, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h0, 4'h0, 4'h0, 1'b1);
        check_val("R2 R10 no match", 10'b0);
        // R3 / R7: return in each of the three stages.
        setv(4'hF, 4'hF, 0, 0, 0, 0, 0, 0, 4'h9, 4'h0, 4'h0, 1'b1);
        check_val("R3 R7 ret in decode", 10'b10_01_00_00_00);
        setv(4'hF, 4'hF, 0, 0, 0, 0, 0, 0, 4'h0, 4'h9, 4'h0, 1'b1);
        check_val("R3 R7 ret in execute", 10'b10_01_00_00_00);
        setv(4'hF, 4'hF, 0, 0, 0, 0, 0, 0, 4'h0, 4'h0, 4'h9, 1'b1);
        check_val("R3 R7 ret in memory", 10'b10_01_00_00_00);
        // R4: taken jump is no mispredict; other opcode with cond 0 neither.
        setv(4'hF, 4'hF, 0, 0, 0, 0, 0, 0, 4'h0, 4'h7, 4'h0, 1'b1);
        check_val("R4 taken jump", 10'b0);
        setv(4'hF, 4'hF, 0, 0, 0, 0, 0, 0, 4'h0, 4'h3, 4'h0, 1'b0);
        check_val("R4 non-jump cond low", 10'b0);
        // All eight combinations of hazard / return / mispredict.
        for (int m = 0; m < 8; m++) begin
            bit h = m[2], r = m[1], j = m[0];
            setv(h ? 4'h5 : 4'hE, 4'hF, 4'h5, 4'h1, 4'h2, 4'h3, 4'h4, 4'h6,
                 r ? 4'h9 : 4'h0, j ? 4'h7 : 4'h0, 4'h0, 1'b0);
            if (j)      check_val("R5 mispredict wins", 10'b00_01_01_00_00);
            else if (h) check_val("R6 hazard over ret", 10'b10_10_01_00_00);
            else if (r) check_val("R7 ret alone", 10'b10_01_00_00_00);
            else        check_val("R10 none", 10'b0);
        end
        // R8 R9: pseudo-random sweep against the model.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] v;
            v = $urandom;
            setv(v[3:0], v[7:4], v[11:8], v[15:12], 4'($urandom), 4'($urandom),
                 4'($urandom), 4'($urandom), (v[16] ? 4'h9 : v[27:24]),
                 (v[17] ? 4'h7 : v[31:28]), (v[18] ? 4'h9 : 4'h0), v[19]);
            check("R8 R9 sweep");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule